// File: doc/BRIEF.md
# Temperature Conversion Arbiter

This block decides when a real-time clock's temperature conversion engine runs. Conversions have two sources. The first is a fixed schedule that fires once every `PERIOD_SEC` ticks of the 1 Hz timebase. The second is software, which writes 1 to the convert bit. The block holds the convert bit and the busy status bit. It sends a one-cycle start pulse to an external conversion engine and waits for that engine's one-cycle done pulse.

A software conversion runs alongside the schedule and never moves it. The schedule counter keeps counting 1 Hz ticks from reset, whatever software does. When software starts a conversion, busy is not raised at once. It goes high only after `DELAY_TICKS` ticks of a faster timebase have passed, and only if the conversion is still running then. If the schedule falls due while a software conversion is running, the scheduled conversion is held back and then started right after the done pulse.

Top module: `tconv_arbiter`

## Requirements
- R1: After reset, conv_bit, busy and eng_start are all 0.
- R2: When idle, a write of 1 (cfg_wr=1, cfg_wdata=1) sets conv_bit and pulses eng_start for one cycle, both visible after the same clock edge. conv_bit then stays 1 until eng_done.
- R3: An eng_done during a software conversion with nothing queued clears conv_bit and busy at that edge.
- R4: During a software conversion, busy stays 0 for the first DELAY_TICKS-1 tick_fast pulses. It goes to 1 at the edge that samples the DELAY_TICKS-th pulse (default 66).
- R5: On every PERIOD_SEC-th tick_1hz pulse (default 64), counted from reset, an idle block pulses eng_start and sets busy at that edge. busy stays 1 until eng_done.
- R6: Software conversions neither delay nor restart the periodic count. A scheduled conversion falls due on tick_1hz number k*PERIOD_SEC after reset for every k.
- R7: A write of 1 during a periodic conversion, or in the same cycle as a due tick while idle, is ignored. conv_bit stays 0 and the periodic conversion proceeds.
- R8: A due tick during a software conversion produces no eng_start at that time. At the eng_done edge that ends the software conversion, eng_start pulses, busy becomes 1 and conv_bit becomes 0.
- R9: A write of 0 during a running software conversion leaves conv_bit at 1 and does not end the conversion.
- R10: eng_done while idle has no effect: conv_bit, busy and eng_start stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| tick_fast | input | 1 | One-cycle pulse of the busy-delay timebase |
| cfg_wr | input | 1 | Write strobe for the convert bit |
| cfg_wdata | input | 1 | Value written to the convert bit |
| eng_done | input | 1 | Conversion engine finished (one-cycle pulse) |
| conv_bit | output | 1 | Convert bit, readable by software |
| busy | output | 1 | Busy status bit |
| eng_start | output | 1 | Start pulse to the conversion engine |

## Verification
A corrupted phase in the schedule counter shows up as an eng_start pulse on the wrong 1 Hz tick. The scheduled conversions that follow land on the wrong ticks as well, so the first scheduled start after the fault exposes it. A lost or stuck queue flag appears at the next done pulse, as a missing or extra start pulse. A wrong busy-delay count moves the rising edge of busy by whole fast ticks within one software conversion. A state machine stuck outside idle shows as busy or conv_bit failing to clear at the edge where done is sampled.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
   typedef enum logic [1:0] {
      TC_IDLE     = 2'd0,
      TC_PERIODIC = 2'd1,
      TC_SOFT     = 2'd2
   } tc_state_e;
endpackage

// File: rtl/tconv_period_timer.sv
module tconv_period_timer #(
   parameter int PERIOD_SEC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1hz,
   output logic due
);
   localparam int CW = (PERIOD_SEC > 1) ? $clog2(PERIOD_SEC) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD_SEC - 1);

   if (PERIOD_SEC < 2) begin : g_bad_period
      $error("PERIOD_SEC must be at least 2");
   end

   logic [CW-1:0] sec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sec_q <= '0;
      else if (tick_1hz) sec_q <= (sec_q == LAST) ? '0 : sec_q + 1'b1;
   end

   assign due = tick_1hz && (sec_q == LAST);

   assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sec_q <= LAST);
   assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_1hz |=> $stable(sec_q));
endmodule

// File: rtl/tconv_busy_delay.sv
module tconv_busy_delay #(
   parameter int DELAY_TICKS = 66
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic tick,
   output logic hit
);
   if (DELAY_TICKS < 0) begin : g_bad_delay
      $error("DELAY_TICKS must not be negative");
   end

   if (DELAY_TICKS == 0) begin : g_none
      assign hit = run;
   end else begin : g_count
      localparam int DW = $clog2(DELAY_TICKS + 1);
      localparam logic [DW-1:0] LIM = DW'(DELAY_TICKS);
      logic [DW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              cnt_q <= '0;
         else if (clear)                          cnt_q <= '0;
         else if (run && tick && cnt_q != LIM)    cnt_q <= cnt_q + 1'b1;
      end

      assign hit = run && tick && (cnt_q == LIM - 1'b1);

      assert_delay_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LIM);
   end
endmodule

// File: rtl/tconv_arbiter.sv
module tconv_arbiter
   import tconv_pkg::*;
#(
   parameter int PERIOD_SEC  = 64,
   parameter int DELAY_TICKS = 66
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_1hz,
   input  logic tick_fast,
   input  logic cfg_wr,
   input  logic cfg_wdata,
   input  logic eng_done,
   output logic conv_bit,
   output logic busy,
   output logic eng_start
);
   tc_state_e st_q;
   logic      pend_q, conv_q, busy_q, start_q;
   logic      due, dly_hit, sw_take;

   tconv_period_timer #(.PERIOD_SEC(PERIOD_SEC)) u_period (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .due(due));

   assign sw_take = (st_q == TC_IDLE) && !due && cfg_wr && cfg_wdata;

   tconv_busy_delay #(.DELAY_TICKS(DELAY_TICKS)) u_delay (
      .clk(clk), .rst_n(rst_n), .clear(sw_take),
      .run((st_q == TC_SOFT) && !busy_q && !eng_done),
      .tick(tick_fast), .hit(dly_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= TC_IDLE;
         pend_q  <= 1'b0;
         conv_q  <= 1'b0;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         unique case (st_q)
            TC_IDLE: begin
               if (due) begin
                  st_q    <= TC_PERIODIC;
                  busy_q  <= 1'b1;
                  start_q <= 1'b1;
               end else if (sw_take) begin
                  st_q    <= TC_SOFT;
                  conv_q  <= 1'b1;
                  start_q <= 1'b1;
               end
            end
            TC_PERIODIC, TC_SOFT: begin
               if (eng_done) begin
                  conv_q <= 1'b0;
                  if (due || pend_q) begin
                     st_q    <= TC_PERIODIC;
                     busy_q  <= 1'b1;
                     start_q <= 1'b1;
                     pend_q  <= 1'b0;
                  end else begin
                     st_q   <= TC_IDLE;
                     busy_q <= 1'b0;
                  end
               end else begin
                  if (due)     pend_q <= 1'b1;
                  if (dly_hit) busy_q <= 1'b1;
               end
            end
            default: st_q <= TC_IDLE;
         endcase
      end
   end

   assign conv_bit  = conv_q;
   assign busy      = busy_q;
   assign eng_start = start_q;

   assert_conv_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_bit) |-> $past(cfg_wr && cfg_wdata));
   assert_conv_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_bit && eng_done) |=> !conv_bit);
   assert_busy_delayed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && conv_bit) |-> $past(dly_hit));
   assert_periodic_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (due && st_q == TC_IDLE) |=> (busy && eng_start));
   assert_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TC_PERIODIC && cfg_wr) |=> !conv_bit);
   assert_queue_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && eng_done) |=> (eng_start && busy && !conv_bit));
   assert_conv_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_bit && !eng_done) |=> conv_bit);
   assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TC_IDLE && eng_done && !due && !cfg_wr) |=> (!busy && !eng_start));
endmodule

// File: tb/sim_tconv_arbiter.sv
module sim_tconv_arbiter;
   localparam int PER = 64;
   localparam int DLY = 66;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_1hz = 0, tick_fast = 0, cfg_wr = 0, cfg_wdata = 0, eng_done = 0;
   logic conv_bit, busy, eng_start;

   int checks = 0, errors = 0;
   bit finished = 0;
   bit auto_chk = 0;

   // bench reference state
   int m_sec = 0, m_st = 0, m_dly = 0;
   bit m_pend = 0, m_conv = 0, m_busy = 0, m_start = 0;

   always #4 clk = ~clk;

   tconv_arbiter #(.PERIOD_SEC(PER), .DELAY_TICKS(DLY)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_fast(tick_fast),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .eng_done(eng_done),
      .conv_bit(conv_bit), .busy(busy), .eng_start(eng_start));

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit ref_due(input bit t1);
      return t1 && (m_sec == PER - 1);
   endfunction

   task automatic ref_update(input bit t1, input bit tf, input bit wr, input bit wd, input bit dn);
      bit due;
      due = ref_due(t1);
      if (t1) m_sec = (m_sec == PER - 1) ? 0 : m_sec + 1;
      m_start = 0;
      case (m_st)
         0: begin
            if (due) begin m_st = 1; m_busy = 1; m_start = 1; end
            else if (wr && wd) begin m_st = 2; m_conv = 1; m_dly = 0; m_start = 1; end
         end
         default: begin
            if (dn) begin
               m_conv = 0;
               if (due || m_pend) begin m_st = 1; m_busy = 1; m_start = 1; m_pend = 0; end
               else begin m_st = 0; m_busy = 0; end
            end else begin
               if (due) m_pend = 1;
               if (m_st == 2 && !m_busy && tf) begin
                  m_dly++;
                  if (m_dly == DLY) m_busy = 1;
               end
            end
         end
      endcase
   endtask

   task automatic step(input bit t1, input bit tf, input bit wr, input bit wd, input bit dn);
      tick_1hz = t1; tick_fast = tf; cfg_wr = wr; cfg_wdata = wd; eng_done = dn;
      @(posedge clk);
      ref_update(t1, tf, wr, wd, dn);
      #2;
      if (auto_chk) begin
         check("R2 conv_bit", conv_bit, m_conv);
         check("R4 busy", busy, m_busy);
         check("R5 eng_start", eng_start, m_start);
      end
      @(negedge clk);
      tick_1hz = 0; tick_fast = 0; cfg_wr = 0; cfg_wdata = 0; eng_done = 0;
   endtask

   task automatic secs(input int n);
      for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int eng_cnt;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      #1;
      check("R1 conv_bit", conv_bit, 1'b0);
      check("R1 busy", busy, 1'b0);
      check("R1 eng_start", eng_start, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // software conversion, delayed busy
      step(0, 0, 1, 1, 0);
      check("R2 conv set", conv_bit, 1'b1);
      check("R2 start pulse", eng_start, 1'b1);
      check("R4 busy not raised", busy, 1'b0);
      step(0, 0, 0, 0, 0);
      check("R2 start single", eng_start, 1'b0);
      check("R2 conv held", conv_bit, 1'b1);
      for (int i = 0; i < DLY - 1; i++) step(0, 1, 0, 0, 0);
      check("R4 busy low before delay", busy, 1'b0);
      step(0, 1, 0, 0, 0);
      check("R4 busy after delay", busy, 1'b1);
      step(0, 0, 1, 0, 0);
      check("R9 write 0 ignored", conv_bit, 1'b1);
      check("R9 busy kept", busy, 1'b1);
      step(0, 0, 0, 0, 1);
      check("R3 conv cleared", conv_bit, 1'b0);
      check("R3 busy cleared", busy, 1'b0);
      step(0, 0, 0, 0, 1);
      check("R10 conv idle", conv_bit, 1'b0);
      check("R10 busy idle", busy, 1'b0);
      check("R10 no start", eng_start, 1'b0);

      // periodic conversion, schedule unaffected by software
      secs(PER - 1);
      check("R6 not yet due", eng_start, 1'b0);
      step(1, 0, 0, 0, 0);
      check("R6 due on tick 64", eng_start, 1'b1);
      check("R5 busy raised", busy, 1'b1);
      step(0, 0, 1, 1, 0);
      check("R7 write during periodic", conv_bit, 1'b0);
      check("R5 busy held", busy, 1'b1);
      step(0, 0, 0, 0, 1);
      check("R5 busy cleared by done", busy, 1'b0);

      // expiry during software conversion gets queued
      secs(PER - 1);
      step(0, 0, 1, 1, 0);
      check("R2 conv set again", conv_bit, 1'b1);
      step(1, 0, 0, 0, 0);
      check("R8 no start while sw runs", eng_start, 1'b0);
      check("R8 busy still delayed", busy, 1'b0);
      step(0, 0, 0, 0, 1);
      check("R8 queued start", eng_start, 1'b1);
      check("R8 busy raised", busy, 1'b1);
      check("R8 conv cleared", conv_bit, 1'b0);
      step(0, 0, 0, 0, 1);
      check("R8 queued done", busy, 1'b0);

      // write in the same cycle as a due tick
      secs(PER - 1);
      step(1, 0, 1, 1, 0);
      check("R7 same-cycle write conv", conv_bit, 1'b0);
      check("R7 same-cycle periodic busy", busy, 1'b1);
      check("R7 same-cycle start", eng_start, 1'b1);
      step(0, 0, 0, 0, 1);
      check("R3 idle again", busy, 1'b0);

      // constrained random phase against the bench reference
      auto_chk = 1;
      eng_cnt = 0;
      for (int c = 0; c < 30000; c++) begin
         bit t1, tf, wr, wd, dn;
         t1 = ($urandom_range(0, 19) == 0);
         tf = ($urandom_range(0, 2) == 0);
         wr = ($urandom_range(0, 39) == 0);
         wd = ($urandom_range(0, 3) != 0);
         dn = 0;
         if (eng_cnt == 1) dn = 1;
         else if (eng_cnt == 0 && $urandom_range(0, 499) == 0) dn = 1;
         if (eng_cnt > 0) eng_cnt--;
         step(t1, tf, wr, wd, dn);
         if (eng_start) eng_cnt = $urandom_range(2, 320);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule